// File: doc/BRIEF.md
# Microprogram Sequencer with Encoded Next-Address Control

This block is the control half of a bus-based processor that runs every machine instruction as a short microroutine. A 6-bit microprogram counter addresses a control store held in logic; each word of the store gives the 17 datapath control lines for one step, plus a 3-bit jump code. The jump code tells a small selector where the counter goes next: the following word, the same word while memory is busy, the start of instruction fetch, the entry point of the current opcode's group, or fetch taken on a zero test. The datapath and memory sit outside. The sequencer sees only the opcode, the memory busy flag and the zero flag.

Opcodes are grouped before dispatch, so one entry point serves a whole class of instructions. The store covers register ALU ops, immediate ALU ops, load, store, branch-if-zero, branch-if-nonzero, jump and jump-and-link. Any opcode outside these classes enters a trap microstate. That state raises `trap` and holds until reset.

Microstates by address: FETCH0-3 (0-3), ALU0-2 (4-6), ALUI0-2 (7-9), LW0-4 (10-14), SW0-4 (15-19), BEQZ0-4 (20-24), BNEZ0-4 (25-29), J0-2 (30-32), JAL0-3 (33-36), ILLEGAL (37).

Transitions by jump code:
- NEXT=0 goes to +1.
- SPIN=1 stays while busy, else goes to +1.
- FETCH=2 goes to 0.
- DISPATCH=3 goes to the group entry.
- FEQZ=4 goes to 0 if zero, else +1.
- FNEZ=5 goes to +1 if zero, else 0.
- HOLD=6 stays.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 (FETCH0) and `trap` is 0. The first clock edge after release starts from FETCH0.
- R2: A NEXT step moves `upc` to `upc`+1 on the next edge, whatever `busy` and `zero` are. FETCH0, FETCH2 and LW0-LW2 are NEXT steps.
- R3: A SPIN step (FETCH1, LW3, SW3) keeps `upc` unchanged on every edge where `busy` is 1. On the first edge with `busy` 0 it moves to `upc`+1.
- R4: A FETCH step (ALU2, ALUI2, LW4, SW4, BEQZ4, BNEZ4, J2, JAL3) returns `upc` to 0 on the next edge.
- R5: The DISPATCH step at FETCH3 loads the group entry for `opcode`. The entries are: 0x00→4, 0x08..0x0F→7, 0x23→10, 0x2B→15, 0x04→20, 0x05→25, 0x02→30, 0x03→33.
- R6: At BEQZ1 (an FNEZ step) the next `upc` is 22 when `zero` is 1 and 0 when it is 0. At BNEZ1 (an FEQZ step) the next `upc` is 0 when `zero` is 1 and 27 when it is 0.
- R7: Any opcode outside the R5 groups dispatches to 37. There `trap` is 1 and `ctrl` is 0, and `upc` stays 37 regardless of `opcode`, `busy` and `zero` until reset.
- R8: The `ctrl` bit layout is:
  - 16: load IR
  - 15: load A
  - 14: load B
  - 13: load MA
  - 12: ALU drives bus
  - 11: register file drives bus
  - 10: register write
  - 9: memory enable
  - 8: memory write
  - 7:5: register select (rs=0, rt=1, rd=2, link=3, PC=4)
  - 4:3: immediate mode
  - 2:0: ALU op (passA=0, +4=1, add=2, func=3, jump target=4)

  Under this layout FETCH0=0x2880, FETCH1=0x10200, FETCH3=0x1481 and LW3=0x620.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode of the instruction held in IR |
| busy | input | 1 | Memory access still in progress |
| zero | input | 1 | Bus value is zero |
| ctrl | output | 17 | Datapath control lines of the current microstep |
| upc | output | 6 | Current microprogram address |
| trap | output | 1 | Illegal-instruction microstate active |

## Verification
The bench builds the block with its default widths: a 6-bit opcode, a 6-bit microprogram counter and a 17-bit control word. At these widths every one of the 38 microstates can be reached through real dispatches, and the whole opcode space is available. That lets the bench drive two different opcodes from the immediate group, as well as an opcode that lands in the trap. With a narrower opcode field, some groups would alias and the illegal path could not be reached.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int OP_W    = 6;
    localparam int UPC_W   = 6;
    localparam int JT_W    = 3;
    localparam int SEL_W   = 3;
    localparam int EXT_W   = 2;
    localparam int ALUOP_W = 3;
    localparam int CTRL_W  = 9 + SEL_W + EXT_W + ALUOP_W;

    typedef enum logic [JT_W-1:0] {
        JT_NEXT     = 3'd0,
        JT_SPIN     = 3'd1,
        JT_FETCH    = 3'd2,
        JT_DISPATCH = 3'd3,
        JT_FEQZ     = 3'd4,
        JT_FNEZ     = 3'd5,
        JT_HOLD     = 3'd6
    } jump_e;

    typedef enum logic [UPC_W-1:0] {
        US_FETCH0 = 6'd0, US_FETCH1, US_FETCH2, US_FETCH3,
        US_ALU0, US_ALU1, US_ALU2,
        US_ALUI0, US_ALUI1, US_ALUI2,
        US_LW0, US_LW1, US_LW2, US_LW3, US_LW4,
        US_SW0, US_SW1, US_SW2, US_SW3, US_SW4,
        US_BEQZ0, US_BEQZ1, US_BEQZ2, US_BEQZ3, US_BEQZ4,
        US_BNEZ0, US_BNEZ1, US_BNEZ2, US_BNEZ3, US_BNEZ4,
        US_J0, US_J1, US_J2,
        US_JAL0, US_JAL1, US_JAL2, US_JAL3,
        US_ILLEGAL
    } ustate_e;

    localparam logic [SEL_W-1:0]   RS_RS = 3'd0, RS_RT = 3'd1, RS_RD = 3'd2,
                                   RS_LINK = 3'd3, RS_PC = 3'd4;
    localparam logic [EXT_W-1:0]   EX_SEXT = 2'd0, EX_UEXT = 2'd1,
                                   EX_BRANCH = 2'd2, EX_JFIELD = 2'd3;
    localparam logic [ALUOP_W-1:0] OP_PASSA = 3'd0, OP_INC4 = 3'd1,
                                   OP_ADD = 3'd2, OP_FUNC = 3'd3, OP_JTARG = 3'd4;

    localparam logic [OP_W-1:0] OPC_ALU  = 6'h00;
    localparam logic [OP_W-1:0] OPC_J    = 6'h02;
    localparam logic [OP_W-1:0] OPC_JAL  = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQZ = 6'h04;
    localparam logic [OP_W-1:0] OPC_BNEZ = 6'h05;
    localparam logic [2:0]      OPC_ALUI_HI = 3'b001;
    localparam logic [OP_W-1:0] OPC_LW   = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW   = 6'h2B;

    typedef struct packed {
        logic                ld_ir;
        logic                ld_a;
        logic                ld_b;
        logic                ld_ma;
        logic                en_alu;
        logic                en_reg;
        logic                reg_wr;
        logic                en_mem;
        logic                mem_wr;
        logic [SEL_W-1:0]    sel_reg;
        logic [EXT_W-1:0]    sel_ext;
        logic [ALUOP_W-1:0]  sel_op;
    } ctrl_t;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    output ctrl_t            ctrl,
    output jump_e            jt
);
    always_comb begin
        ctrl = '0;
        jt   = JT_NEXT;
        unique case (ustate_e'(upc))
            US_FETCH0: begin
                ctrl.ld_ma = 1'b1; ctrl.en_reg = 1'b1; ctrl.sel_reg = RS_PC;
            end
            US_FETCH1: begin
                ctrl.ld_ir = 1'b1; ctrl.en_mem = 1'b1; jt = JT_SPIN;
            end
            US_FETCH2, US_BEQZ2, US_BNEZ2, US_J0, US_JAL0: begin
                ctrl.ld_a = 1'b1; ctrl.en_reg = 1'b1; ctrl.sel_reg = RS_PC;
            end
            US_FETCH3: begin
                ctrl.en_alu = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_PC;
                ctrl.sel_op = OP_INC4; jt = JT_DISPATCH;
            end
            US_ALU0, US_ALUI0, US_LW0, US_SW0, US_BEQZ0, US_BNEZ0: begin
                ctrl.ld_a = 1'b1; ctrl.en_reg = 1'b1; ctrl.sel_reg = RS_RS;
            end
            US_ALU1: begin
                ctrl.ld_b = 1'b1; ctrl.en_reg = 1'b1; ctrl.sel_reg = RS_RT;
            end
            US_ALU2: begin
                ctrl.en_alu = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_RD;
                ctrl.sel_op = OP_FUNC; jt = JT_FETCH;
            end
            US_ALUI1, US_LW1, US_SW1: begin
                ctrl.ld_b = 1'b1; ctrl.sel_ext = EX_SEXT;
            end
            US_ALUI2: begin
                ctrl.en_alu = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_RT;
                ctrl.sel_op = OP_FUNC; jt = JT_FETCH;
            end
            US_LW2, US_SW2: begin
                ctrl.ld_ma = 1'b1; ctrl.en_alu = 1'b1; ctrl.sel_op = OP_ADD;
            end
            US_LW3: begin
                ctrl.en_mem = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_RT;
                jt = JT_SPIN;
            end
            US_SW3: begin
                ctrl.en_mem = 1'b1; ctrl.mem_wr = 1'b1; ctrl.en_reg = 1'b1;
                ctrl.sel_reg = RS_RT; jt = JT_SPIN;
            end
            US_LW4, US_SW4: jt = JT_FETCH;
            US_BEQZ1: jt = JT_FNEZ;
            US_BNEZ1: jt = JT_FEQZ;
            US_BEQZ3, US_BNEZ3: begin
                ctrl.ld_b = 1'b1; ctrl.sel_ext = EX_BRANCH;
            end
            US_BEQZ4, US_BNEZ4: begin
                ctrl.en_alu = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_PC;
                ctrl.sel_op = OP_ADD; jt = JT_FETCH;
            end
            US_J1, US_JAL2: begin
                ctrl.ld_b = 1'b1; ctrl.sel_ext = EX_JFIELD;
            end
            US_J2, US_JAL3: begin
                ctrl.en_alu = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_PC;
                ctrl.sel_op = OP_JTARG; jt = JT_FETCH;
            end
            US_JAL1: begin
                ctrl.en_alu = 1'b1; ctrl.reg_wr = 1'b1; ctrl.sel_reg = RS_LINK;
                ctrl.sel_op = OP_PASSA;
            end
            US_ILLEGAL: jt = JT_HOLD;
            default: jt = JT_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    output logic [UPC_W-1:0] entry
);
    typedef enum logic [3:0] {
        GRP_ALU, GRP_ALUI, GRP_LW, GRP_SW, GRP_BEQZ, GRP_BNEZ,
        GRP_J, GRP_JAL, GRP_NONE
    } group_e;

    group_e grp;

    always_comb begin
        if (opcode[OP_W-1:OP_W-3] == OPC_ALUI_HI) begin
            grp = GRP_ALUI;
        end else begin
            unique case (opcode)
                OPC_ALU:  grp = GRP_ALU;
                OPC_LW:   grp = GRP_LW;
                OPC_SW:   grp = GRP_SW;
                OPC_BEQZ: grp = GRP_BEQZ;
                OPC_BNEZ: grp = GRP_BNEZ;
                OPC_J:    grp = GRP_J;
                OPC_JAL:  grp = GRP_JAL;
                default:  grp = GRP_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (grp)
            GRP_ALU:  entry = US_ALU0;
            GRP_ALUI: entry = US_ALUI0;
            GRP_LW:   entry = US_LW0;
            GRP_SW:   entry = US_SW0;
            GRP_BEQZ: entry = US_BEQZ0;
            GRP_BNEZ: entry = US_BNEZ0;
            GRP_J:    entry = US_J0;
            GRP_JAL:  entry = US_JAL0;
            default:  entry = US_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  jump_e            jt,
    input  logic             busy,
    input  logic             zero,
    input  logic [UPC_W-1:0] entry,
    output logic [UPC_W-1:0] upc_q
);
    logic [UPC_W-1:0] upc_inc;
    logic [UPC_W-1:0] upc_d;

    assign upc_inc = upc_q + UPC_W'(1);

    always_comb begin
        unique case (jt)
            JT_NEXT:     upc_d = upc_inc;
            JT_SPIN:     upc_d = busy ? upc_q : upc_inc;
            JT_FETCH:    upc_d = US_FETCH0;
            JT_DISPATCH: upc_d = entry;
            JT_FEQZ:     upc_d = zero ? UPC_W'(US_FETCH0) : upc_inc;
            JT_FNEZ:     upc_d = zero ? upc_inc : UPC_W'(US_FETCH0);
            JT_HOLD:     upc_d = upc_q;
            default:     upc_d = US_FETCH0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upc_q <= US_FETCH0;
        else        upc_q <= upc_d;
    end

    // R2
    next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_NEXT) |=> (upc_q == UPC_W'($past(upc_q) + 1)));

    // R3
    spin_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_SPIN && busy) |=> $stable(upc_q));

    // R4
    fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_FETCH) |=> (upc_q == UPC_W'(US_FETCH0)));

    // R6
    feqz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_FEQZ && zero) |=> (upc_q == UPC_W'(US_FETCH0)));

    // R6
    fnez_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_FNEZ && zero) |=> (upc_q == UPC_W'($past(upc_q) + 1)));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic              busy,
    input  logic              zero,
    output logic [CTRL_W-1:0] ctrl,
    output logic [UPC_W-1:0]  upc,
    output logic              trap
);
    ctrl_t            word;
    jump_e            jt;
    logic [UPC_W-1:0] entry;
    logic [UPC_W-1:0] upc_q;

    useq_rom u_rom (
        .upc  (upc_q),
        .ctrl (word),
        .jt   (jt)
    );

    useq_dispatch u_disp (
        .opcode (opcode),
        .entry  (entry)
    );

    useq_next u_next (
        .clk   (clk),
        .rst_n (rst_n),
        .jt    (jt),
        .busy  (busy),
        .zero  (zero),
        .entry (entry),
        .upc_q (upc_q)
    );

    assign ctrl = word;
    assign upc  = upc_q;
    assign trap = (upc_q == UPC_W'(US_ILLEGAL));

    // R7
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (trap && $stable(upc)));

    // R7
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (ctrl == '0));

    // R5
    dispatch_lw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jt == JT_DISPATCH && opcode == OPC_LW) |=> (upc == UPC_W'(US_LW0)));
endmodule

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic        busy = 1'b0;
    logic        zero = 1'b0;
    logic [16:0] ctrl;
    logic [5:0]  upc;
    logic        trap;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    useq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .busy(busy),
        .zero(zero), .ctrl(ctrl), .upc(upc), .trap(trap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; busy = 1'b0; zero = 1'b0; opcode = '0;
        #1;
        chk("R1 upc in reset", 32'(upc), 32'd0);
        chk("R1 trap in reset", 32'(trap), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic goto_group(input logic [5:0] op);
        busy = 1'b0;
        tick(); tick(); tick();
        opcode = op;
        tick();
    endtask

    task automatic walk(input int start, input int len, input logic z);
        zero = z;
        for (int i = 1; i < len; i++) tick();
        chk("R2 walk to last step", 32'(upc), 32'(start + len - 1));
        tick();
        chk("R4 return to fetch", 32'(upc), 32'd0);
    endtask

    task automatic t_reset_word();
        do_reset();
        chk("R8 FETCH0 word", 32'(ctrl), 32'h2880);
        tick();
        chk("R1 first step after reset", 32'(upc), 32'd1);
    endtask

    task automatic t_fetch_spin();
        do_reset();
        busy = 1'b1; zero = 1'b1;
        tick();
        chk("R2 NEXT ignores busy", 32'(upc), 32'd1);
        chk("R8 FETCH1 word", 32'(ctrl), 32'h10200);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 spin holds", 32'(upc), 32'd1);
        end
        busy = 1'b0;
        tick();
        chk("R3 spin releases", 32'(upc), 32'd2);
        tick();
        chk("R2 FETCH2 to FETCH3", 32'(upc), 32'd3);
        chk("R8 FETCH3 word", 32'(ctrl), 32'h1481);
    endtask

    task automatic t_dispatch(input logic [5:0] op, input int start, input int len, input logic z);
        do_reset();
        goto_group(op);
        chk($sformatf("R5 entry for op 0x%0h", op), 32'(upc), 32'(start));
        chk("R7 no trap on legal op", 32'(trap), 32'd0);
        walk(start, len, z);
    endtask

    task automatic t_load_spin();
        do_reset();
        goto_group(6'h23);
        tick(); tick(); tick();
        chk("R2 reach LW3", 32'(upc), 32'd13);
        chk("R8 LW3 word", 32'(ctrl), 32'h620);
        busy = 1'b1;
        tick(); tick();
        chk("R3 LW3 waits on busy", 32'(upc), 32'd13);
        busy = 1'b0;
        tick();
        chk("R3 LW3 advances", 32'(upc), 32'd14);
        tick();
        chk("R4 LW4 fetch", 32'(upc), 32'd0);
    endtask

    task automatic t_branches();
        do_reset();
        goto_group(6'h04);
        tick();
        zero = 1'b0;
        tick();
        chk("R6 BEQZ not taken", 32'(upc), 32'd0);
        goto_group(6'h05);
        tick();
        zero = 1'b1;
        tick();
        chk("R6 BNEZ not taken", 32'(upc), 32'd0);
        goto_group(6'h05);
        tick();
        zero = 1'b0;
        tick();
        chk("R6 BNEZ taken", 32'(upc), 32'd27);
        do_reset();
        goto_group(6'h04);
        tick();
        zero = 1'b1;
        tick();
        chk("R6 BEQZ taken", 32'(upc), 32'd22);
    endtask

    task automatic t_illegal();
        do_reset();
        goto_group(6'h3F);
        chk("R7 illegal entry", 32'(upc), 32'd37);
        chk("R7 trap raised", 32'(trap), 32'd1);
        chk("R7 trap word", 32'(ctrl), 32'd0);
        opcode = 6'h00; busy = 1'b1; zero = 1'b1;
        tick(); tick();
        opcode = 6'h23; busy = 1'b0; zero = 1'b0;
        tick();
        chk("R7 trap holds", 32'(upc), 32'd37);
        chk("R7 trap stays", 32'(trap), 32'd1);
        do_reset();
        chk("R1 reset clears trap", 32'(trap), 32'd0);
    endtask

    initial begin
        t_reset_word();
        t_fetch_spin();
        t_dispatch(6'h00, 4, 3, 1'b0);
        t_dispatch(6'h08, 7, 3, 1'b0);
        t_dispatch(6'h0F, 7, 3, 1'b1);
        t_dispatch(6'h23, 10, 5, 1'b0);
        t_dispatch(6'h2B, 15, 5, 1'b0);
        t_dispatch(6'h04, 20, 5, 1'b1);
        t_dispatch(6'h05, 25, 5, 1'b0);
        t_dispatch(6'h02, 30, 3, 1'b0);
        t_dispatch(6'h03, 33, 4, 1'b1);
        t_load_spin();
        t_branches();
        t_illegal();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule